// File: doc/BRIEF.md
# Transmit Queue with Level-Triggered Interrupt

This block buffers bytes written by a host on their way to a serial transmit shifter. It holds up to 128 bytes in arrival order, shows the oldest byte to the shifter and removes it on the shifter's pop request. A fill counter can be read at all times. Two status flags are produced: one says the queue holds no byte, the other says the queue is empty and the shifter is idle as well.

A transmit interrupt asks the host for more data. It becomes pending when a pop takes the fill level from at or above a programmable threshold to below it, or when a pop empties the queue. It is dropped when a host write lifts the level back to or over the threshold, or when the host acknowledges the interrupt source. An enable input masks the interrupt output without losing the pending state. With queueing turned off, the block acts as a one-byte holding register whose threshold is fixed at one.

Top module: `tx_hold_queue`

## Requirements
- R1: After reset the level is 0, both empty flags are 1 (shifter idle) and the interrupt is 0.
- R2: Bytes leave in the order they were written; `rd_data_o` shows the oldest byte; the level goes up by one after a write, down by one after a pop, and is unchanged after a write and a pop in the same cycle, each visible in the next cycle.
- R3: A write while the level equals the capacity (128 in queue mode) is discarded, even if a pop happens in the same cycle; the level never exceeds 128 and stored bytes are not disturbed.
- R4: `thr_empty_o` is 1 exactly when the level is 0.
- R5: `tx_empty_o` is 1 exactly when the level is 0 and `shift_busy_i` is 0.
- R6: With `fifo_en_i` = 0 the capacity is one byte: a second write before a pop is discarded and the first byte is kept.
- R7: The interrupt becomes pending on a pop (without a write in the same cycle) that takes the level from at least the effective threshold to below it, or that makes the level 0. The effective threshold is `trig_lvl_i` in queue mode and 1 with `fifo_en_i` = 0.
- R8: `irq_o` is the pending state gated by `irq_en_i`; dropping the enable forces `irq_o` to 0 and restoring it shows the pending state again.
- R9: The pending interrupt is cleared by an accepted write whose resulting level is at least the effective threshold, or by `irq_ack_i` (a set event in the same cycle wins).
- R10: Any change of `fifo_en_i` empties the queue: the level reads 0 in the next cycle and a write in that cycle is discarded.
- R11: A pop while the level is 0 is ignored: the level stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| pop_i | input | 1 | Shifter takes the oldest byte |
| shift_busy_i | input | 1 | Shifter is sending a byte |
| trig_lvl_i | input | 8 | Interrupt threshold (queue mode) |
| fifo_en_i | input | 1 | 1: 128-byte queue, 0: single holding byte |
| irq_en_i | input | 1 | Interrupt output enable |
| irq_ack_i | input | 1 | Host read of the interrupt source |
| rd_data_o | output | 8 | Oldest byte, valid when level is nonzero |
| level_o | output | 8 | Fill level |
| thr_empty_o | output | 1 | Queue empty |
| tx_empty_o | output | 1 | Queue empty and shifter idle |
| irq_o | output | 1 | Transmit interrupt |

## Verification
The assertions take for granted that inputs are stable around the clock edge and that the mode input changes only as a level, so that the cycle after a mode change is a flush cycle. The level-step and overflow properties rely on the block itself refusing writes at capacity, so the stimulus deliberately writes past 128 and pops an empty queue to drive those paths. The bench changes inputs only on the falling edge and never toggles the mode on the same edge as a pop whose effect it checks.

// File: rtl/txq_pkg.sv
package txq_pkg;
  function automatic int unsigned cnt_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic          pop_req_i,
  input  logic [CW-1:0] cap_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [CW-1:0] level_o,
  output logic [CW-1:0] level_next_o
);
  logic [CW-1:0] level_q;

  // writes at capacity are refused even with a pop in the same cycle
  assign push_o = wr_i && !flush_i && (level_q < cap_i);
  assign pop_o  = pop_req_i && !flush_i && (level_q != '0);

  always_comb begin
    level_next_o = level_q;
    if (flush_i)               level_next_o = '0;
    else if (push_o && !pop_o) level_next_o = level_q + 1'b1;
    else if (pop_o && !push_o) level_next_o = level_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= '0;
    else         level_q <= level_next_o;
  end

  assign level_o = level_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CW'(DEPTH));

  a_r2_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + 1'b1)
                 || (level_q + 1'b1 == $past(level_q)));

  a_r11_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && !wr_i && level_q == '0) |=> level_q == '0);

  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_q == '0);
endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] level_i,
  input  logic [CW-1:0] level_next_i,
  input  logic [CW-1:0] trig_i,
  input  logic          ack_i,
  input  logic          en_i,
  output logic          irq_o
);
  logic pend_q, set_evt, clr_evt;

  assign set_evt = pop_i && !push_i &&
                   (((level_i >= trig_i) && (level_next_i < trig_i)) || (level_next_i == '0));
  assign clr_evt = (push_i && (level_next_i >= trig_i)) || ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_evt) pend_q <= 1'b0;
  end

  assign irq_o = pend_q && en_i;

  a_r8_irq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_o);

  a_r9_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_evt) |=> !pend_q);

  a_r7_empty_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && level_i == CW'(1)) |=> pend_q);
endmodule

// File: rtl/tx_hold_queue.sv
module tx_hold_queue
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       pop_i,
  input  logic                       shift_busy_i,
  input  logic [cnt_w(DEPTH)-1:0]    trig_lvl_i,
  input  logic                       fifo_en_i,
  input  logic                       irq_en_i,
  input  logic                       irq_ack_i,
  output logic [DW-1:0]              rd_data_o,
  output logic [cnt_w(DEPTH)-1:0]    level_o,
  output logic                       thr_empty_o,
  output logic                       tx_empty_o,
  output logic                       irq_o
);
  localparam int unsigned CW = cnt_w(DEPTH);

  logic          mode_q, flush;
  logic          push, pop;
  logic [CW-1:0] cap, eff_trig, level, level_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end

  assign flush    = fifo_en_i != mode_q;
  assign cap      = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign eff_trig = fifo_en_i ? trig_lvl_i : CW'(1);

  txq_level #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk_i, .rst_ni,
    .flush_i      (flush),
    .wr_i         (wr_en_i),
    .pop_req_i    (pop_i),
    .cap_i        (cap),
    .push_o       (push),
    .pop_o        (pop),
    .level_o      (level),
    .level_next_o (level_next)
  );

  txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (wr_data_i),
    .rdata_o (rd_data_o)
  );

  txq_irq #(.CW(CW)) u_irq (
    .clk_i, .rst_ni,
    .push_i       (push),
    .pop_i        (pop),
    .level_i      (level),
    .level_next_i (level_next),
    .trig_i       (eff_trig),
    .ack_i        (irq_ack_i),
    .en_i         (irq_en_i),
    .irq_o        (irq_o)
  );

  assign level_o     = level;
  assign thr_empty_o = level == '0;
  assign tx_empty_o  = thr_empty_o && !shift_busy_i;

  a_r6_single_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> level <= CW'(1));

  a_r5_tx_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (thr_empty_o && !shift_busy_i));
endmodule

// File: tb/sim_tx_hold_queue.sv
module sim_tx_hold_queue;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, pop = 1'b0, busy = 1'b0;
  logic [7:0] wdata = '0, trig = 8'd2;
  logic       fen = 1'b0, ien = 1'b0, ack = 1'b0;
  logic [7:0] rdata, level;
  logic       thr_e, tx_e, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  tx_hold_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wdata), .pop_i(pop),
    .shift_busy_i(busy), .trig_lvl_i(trig), .fifo_en_i(fen), .irq_en_i(ien),
    .irq_ack_i(ack), .rd_data_o(rdata), .level_o(level), .thr_empty_o(thr_e),
    .tx_empty_o(tx_e), .irq_o(irq)
  );

  typedef struct packed {
    logic       wr;
    logic       pp;
    logic [7:0] din;
    logic [7:0] lvl;
    logic [7:0] head;
    logic       irq;
  } vec_t;

  // trigger 2, queue mode, interrupt enabled
  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b0, 8'hA1, 8'd1, 8'hA1, 1'b0},
    '{1'b1, 1'b0, 8'hB2, 8'd2, 8'hA1, 1'b0},
    '{1'b1, 1'b0, 8'hC3, 8'd3, 8'hA1, 1'b0},
    '{1'b0, 1'b1, 8'h00, 8'd2, 8'hB2, 1'b0},
    '{1'b0, 1'b1, 8'h00, 8'd1, 8'hC3, 1'b1},
    '{1'b1, 1'b1, 8'hD4, 8'd1, 8'hD4, 1'b1},
    '{1'b1, 1'b0, 8'hE5, 8'd2, 8'hD4, 1'b0},
    '{1'b0, 1'b1, 8'h00, 8'd1, 8'hE5, 1'b1},
    '{1'b0, 1'b1, 8'h00, 8'd0, 8'h00, 1'b1},
    '{1'b0, 1'b1, 8'h00, 8'd0, 8'h00, 1'b1},
    '{1'b1, 1'b0, 8'hF6, 8'd1, 8'hF6, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wdata = d; tick(); wr_en = 1'b0;
  endtask

  task automatic pp();
    pop = 1'b1; tick(); pop = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 level", level, 0);
    check("R1 thr_empty", thr_e, 1);
    check("R1 tx_empty", tx_e, 1);
    check("R1 irq", irq, 0);
    fen = 1'b1; ien = 1'b1; trig = 8'd2;
    tick(); tick();
    check("R10 level after mode change", level, 0);

    foreach (VECS[i]) begin
      wr_en = VECS[i].wr; pop = VECS[i].pp; wdata = VECS[i].din;
      tick();
      wr_en = 1'b0; pop = 1'b0;
      check($sformatf("R2 vec %0d level", i), level, VECS[i].lvl);
      if (VECS[i].lvl != 0) check($sformatf("R2 vec %0d head", i), rdata, VECS[i].head);
      check($sformatf("R7/R9 vec %0d irq", i), irq, VECS[i].irq);
      check($sformatf("R4 vec %0d thr_empty", i), thr_e, VECS[i].lvl == 0);
    end
    check("R11 pop on empty kept level", level, 1);

    ien = 1'b0; tick();
    check("R8 masked irq", irq, 0);
    ien = 1'b1; tick();
    check("R8 pending restored", irq, 1);
    do_ack();
    check("R9 ack clears", irq, 0);
    pp();
    check("R7 empty sets irq", irq, 1);
    do_ack();

    for (int i = 0; i < 130; i++) wr(8'(i + 3));
    check("R3 level saturates", level, 128);
    check("R9 write to trigger cleared", irq, 0);
    wr_en = 1'b1; wdata = 8'hEE; pop = 1'b1; tick(); wr_en = 1'b0; pop = 1'b0;
    check("R3 write at full with pop discarded", level, 127);
    for (int i = 1; i < 128; i++) begin
      if (rdata != 8'(i + 3)) check($sformatf("R3 order at %0d", i), rdata, 8'(i + 3));
      pp();
    end
    n_run++;
    check("R3 drained", level, 0);
    do_ack();

    busy = 1'b1; #1;
    check("R5 busy empty", tx_e, 0);
    check("R4 thr_empty while busy", thr_e, 1);
    busy = 1'b0; wr(8'h5A);
    check("R5 data pending", tx_e, 0);
    check("R4 not empty", thr_e, 0);
    pp();
    check("R5 idle empty", tx_e, 1);
    do_ack();

    wr(8'h01); wr(8'h02); wr(8'h03);
    fen = 1'b0; wr_en = 1'b1; wdata = 8'h77; tick(); wr_en = 1'b0;
    check("R10 flush on mode change", level, 0);
    wr(8'h11); wr(8'h22);
    check("R6 single capacity", level, 1);
    check("R6 first byte kept", rdata, 8'h11);
    do_ack();
    pp();
    check("R7 holding mode threshold one", irq, 1);
    check("R6 drained", level, 0);

    fen = 1'b1; tick(); do_ack(); trig = 8'd0;
    wr(8'h33);
    check("R9 no set on write", irq, 0);
    pp();
    check("R7 empty with threshold 0", irq, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule